// File: doc/BRIEF.md
# Precise Exception Commit Stage

This block is the last stage of an in-order pipeline. One instruction per cycle arrives at its input. Each instruction carries a valid bit and its PC. It may also carry a register write request, a memory store request, and an exception flag with a cause code. Earlier stages only attach exception flags. Nothing is acted on until the instruction sits in this stage's slot, which is the single commit point of the machine. Register-file and memory writes leave the block only from that slot, and only for a valid instruction without an exception.

When the instruction in the slot carries an exception, none of its writes go out. The stage latches its PC into the EPC register and its code into the cause register. For the next cycle it raises a flush together with a fixed handler vector for fetch. Younger instructions are discarded at the input: the one arriving in the trap cycle and the one arriving during the flush. So the first exception in program order is always the one reported, even when a younger instruction behind it was flagged sooner.

Top module: `commit_stage`

## Requirements
- R1: While reset is high and in the cycle after it, epc and cause read zero, flush is low, and rf_we and mem_we are low.
- R2: A valid instruction without an exception whose in_rf_en is set produces rf_we high for exactly one cycle, with its register address and data. This happens in the cycle after the clock edge that samples it.
- R3: A valid instruction without an exception whose in_st_en is set produces mem_we high with its store address and data. Timing is the same as in R2.
- R4: A bubble (in_valid low) writes nothing, raises no flush and leaves epc and cause unchanged. epc and cause change only in a flush cycle.
- R5: An instruction with in_exc set produces neither rf_we nor mem_we, even when it requests writes.
- R6: In the cycle after a faulting instruction occupies the slot, flush is high for exactly one cycle. In that cycle redirect_pc equals HANDLER_VEC, epc equals the faulting PC and cause equals its code.
- R7: The instructions presented in the trap cycle and in the flush cycle are discarded. They produce no writes and no exception. Normal commit resumes with the next instruction.
- R8: An instruction immediately older than a faulting one commits its writes in full.
- R9: When two back-to-back instructions both carry exceptions, only the older one is reported. epc and cause keep its PC and code.
- R10: An instruction requesting both a register write and a store performs both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | instruction present |
| in_pc | input | 32 | instruction PC |
| in_exc | input | 1 | instruction carries an exception |
| in_cause | input | 4 | exception cause code |
| in_rf_en | input | 1 | register write requested |
| in_rf_addr | input | 5 | destination register |
| in_rf_data | input | 32 | register write data |
| in_st_en | input | 1 | store requested |
| in_st_addr | input | 32 | store address |
| in_st_data | input | 32 | store data |
| rf_we | output | 1 | register write commit strobe |
| rf_waddr | output | 5 | committed register address |
| rf_wdata | output | 32 | committed register data |
| mem_we | output | 1 | store commit strobe |
| mem_addr | output | 32 | committed store address |
| mem_wdata | output | 32 | committed store data |
| flush | output | 1 | invalidate younger in-flight instructions |
| redirect_pc | output | 32 | fetch target, HANDLER_VEC while flush is high |
| epc | output | 32 | PC of the last taken exception |
| cause | output | 4 | code of the last taken exception |

## Verification
The assertions assume that reset is held high at the first clock edge. They also assume that the exception flag and cause are final when an instruction reaches the input. The block never re-derives or merges exception information. The stimulus holds reset for several cycles before any instruction is sent, and it changes inputs only on the falling clock edge. Instructions are sent in a directed sequence first, then at random. Exceptions are frequent enough in the random part to produce back-to-back faults and faults during a flush.

// File: rtl/commit_pkg.sv
package commit_pkg;
    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int CAUSE_W = 4;

    typedef struct packed {
        logic               valid;
        logic [XLEN-1:0]    pc;
        logic               exc;
        logic [CAUSE_W-1:0] code;
        logic               rf_en;
        logic [REG_AW-1:0]  rf_addr;
        logic [XLEN-1:0]    rf_data;
        logic               st_en;
        logic [XLEN-1:0]    st_addr;
        logic [XLEN-1:0]    st_data;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '0;

    // instruction may update architected state
    function automatic logic slot_retires(slot_t s);
        return s.valid && !s.exc;
    endfunction

    // instruction redirects control to the handler
    function automatic logic slot_traps(slot_t s);
        return s.valid && s.exc;
    endfunction
endpackage

// File: rtl/commit_slot.sv
module commit_slot
    import commit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  kill,
    input  slot_t d,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst || kill) begin
            q <= EMPTY_SLOT;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/commit_decide.sv
module commit_decide
    import commit_pkg::*;
(
    input  slot_t              s,
    output logic               rf_we,
    output logic [REG_AW-1:0]  rf_waddr,
    output logic [XLEN-1:0]    rf_wdata,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    output logic               take,
    output logic [XLEN-1:0]    take_pc,
    output logic [CAUSE_W-1:0] take_code
);
    logic retire;

    always_comb begin
        retire    = slot_retires(s);
        rf_we     = retire && s.rf_en;
        mem_we    = retire && s.st_en;
        rf_waddr  = s.rf_addr;
        rf_wdata  = s.rf_data;
        mem_addr  = s.st_addr;
        mem_wdata = s.st_data;
        take      = slot_traps(s);
        take_pc   = s.pc;
        take_code = s.code;
    end
endmodule

// File: rtl/commit_trap_regs.sv
module commit_trap_regs
    import commit_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic [XLEN-1:0]    take_pc,
    input  logic [CAUSE_W-1:0] take_code,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause,
    output logic               flush,
    output logic [XLEN-1:0]    redirect_pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc   <= '0;
            cause <= '0;
            flush <= 1'b0;
        end else begin
            flush <= take;
            if (take) begin
                epc   <= take_pc;
                cause <= take_code;
            end
        end
    end

    assign redirect_pc = flush ? HANDLER_VEC : '0;
endmodule

// File: rtl/commit_stage.sv
module commit_stage
    import commit_pkg::*;
#(
    parameter logic [31:0] HANDLER_VEC = 32'h0000_0080
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [31:0]  in_pc,
    input  logic         in_exc,
    input  logic [3:0]   in_cause,
    input  logic         in_rf_en,
    input  logic [4:0]   in_rf_addr,
    input  logic [31:0]  in_rf_data,
    input  logic         in_st_en,
    input  logic [31:0]  in_st_addr,
    input  logic [31:0]  in_st_data,
    output logic         rf_we,
    output logic [4:0]   rf_waddr,
    output logic [31:0]  rf_wdata,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [31:0]  mem_wdata,
    output logic         flush,
    output logic [31:0]  redirect_pc,
    output logic [31:0]  epc,
    output logic [3:0]   cause
);
    slot_t               in_slot;
    slot_t               stg_q;
    logic                take;
    logic [XLEN-1:0]     take_pc;
    logic [CAUSE_W-1:0]  take_code;
    logic                kill;

    always_comb begin
        in_slot.valid   = in_valid;
        in_slot.pc      = in_pc;
        in_slot.exc     = in_exc;
        in_slot.code    = in_cause;
        in_slot.rf_en   = in_rf_en;
        in_slot.rf_addr = in_rf_addr;
        in_slot.rf_data = in_rf_data;
        in_slot.st_en   = in_st_en;
        in_slot.st_addr = in_st_addr;
        in_slot.st_data = in_st_data;
    end

    // younger instructions are dropped in the trap cycle and the flush cycle
    assign kill = take || flush;

    commit_slot u_slot (
        .clk (clk),
        .rst (rst),
        .kill(kill),
        .d   (in_slot),
        .q   (stg_q)
    );

    commit_decide u_decide (
        .s        (stg_q),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .take     (take),
        .take_pc  (take_pc),
        .take_code(take_code)
    );

    commit_trap_regs #(.HANDLER_VEC(HANDLER_VEC)) u_trap (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .take_pc    (take_pc),
        .take_code  (take_code),
        .epc        (epc),
        .cause      (cause),
        .flush      (flush),
        .redirect_pc(redirect_pc)
    );
endmodule

// File: rtl/commit_stage_chk.sv
module commit_stage_chk #(
    parameter logic [31:0] HANDLER_VEC = 32'h0000_0080
) (
    input logic        clk,
    input logic        rst,
    input logic        take,
    input logic [31:0] take_pc,
    input logic [3:0]  take_code,
    input logic        rf_we,
    input logic        mem_we,
    input logic        flush,
    input logic [31:0] redirect_pc,
    input logic [31:0] epc,
    input logic [3:0]  cause
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (epc == '0 && cause == '0 && !flush));

    p_no_write_trap_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (!rf_we && !mem_we));

    p_flush_after_take_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> flush);

    p_flush_single_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);

    p_epc_capture_r6: assert property (@(posedge clk) disable iff (rst)
        flush |-> (epc == $past(take_pc) && cause == $past(take_code)));

    p_vector_r6: assert property (@(posedge clk) disable iff (rst)
        flush |-> redirect_pc == HANDLER_VEC);

    p_quiet_flush_r7: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!rf_we && !mem_we && !take));

    p_trap_regs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !flush |-> ($stable(epc) && $stable(cause)));
endmodule

bind commit_stage commit_stage_chk #(.HANDLER_VEC(HANDLER_VEC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .take_pc    (take_pc),
    .take_code  (take_code),
    .rf_we      (rf_we),
    .mem_we     (mem_we),
    .flush      (flush),
    .redirect_pc(redirect_pc),
    .epc        (epc),
    .cause      (cause)
);

// File: tb/commit_stage_tb.sv
`timescale 1ns/1ps
module commit_stage_tb;
    localparam logic [31:0] HVEC = 32'h0000_0080;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic        in_valid = 0, in_exc = 0, in_rf_en = 0, in_st_en = 0;
    logic [31:0] in_pc = 0, in_rf_data = 0, in_st_addr = 0, in_st_data = 0;
    logic [3:0]  in_cause = 0;
    logic [4:0]  in_rf_addr = 0;
    logic        rf_we, mem_we, flush;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata, mem_addr, mem_wdata, redirect_pc, epc;
    logic [3:0]  cause;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #5 clk = ~clk;

    commit_stage #(.HANDLER_VEC(HVEC)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_pc(in_pc), .in_exc(in_exc), .in_cause(in_cause),
        .in_rf_en(in_rf_en), .in_rf_addr(in_rf_addr), .in_rf_data(in_rf_data),
        .in_st_en(in_st_en), .in_st_addr(in_st_addr), .in_st_data(in_st_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .flush(flush), .redirect_pc(redirect_pc), .epc(epc), .cause(cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: the instruction in the commit slot plus trap state
    bit          m_v, m_exc, m_rfe, m_ste, m_flush;
    logic [31:0] m_pc, m_rfd, m_sta, m_std, m_epc;
    logic [3:0]  m_code, m_cause;
    logic [4:0]  m_rfa;

    always @(posedge clk) begin
        bit tk;
        if (rst) begin
            m_v = 0; m_flush = 0; m_epc = 0; m_cause = 0; m_exc = 0;
        end else begin
            tk = m_v && m_exc;
            if (tk) begin m_epc = m_pc; m_cause = m_code; end
            if (tk || m_flush) m_v = 0;
            else begin
                m_v = in_valid; m_pc = in_pc; m_exc = in_exc; m_code = in_cause;
                m_rfe = in_rf_en; m_rfa = in_rf_addr; m_rfd = in_rf_data;
                m_ste = in_st_en; m_sta = in_st_addr; m_std = in_st_data;
            end
            m_flush = tk;
        end
        cmp_on = 1;
    end

    always @(negedge clk) begin
        bit erf, emem;
        if (cmp_on && !done) begin
            erf  = m_v && !m_exc && m_rfe;
            emem = m_v && !m_exc && m_ste;
            check("R2 rf_we", {31'd0, rf_we}, {31'd0, erf});
            if (erf) begin
                check("R2 rf_waddr", {27'd0, rf_waddr}, {27'd0, m_rfa});
                check("R2 rf_wdata", rf_wdata, m_rfd);
            end
            check("R3 mem_we", {31'd0, mem_we}, {31'd0, emem});
            if (emem) begin
                check("R3 mem_addr", mem_addr, m_sta);
                check("R3 mem_wdata", mem_wdata, m_std);
            end
            check("R6 flush", {31'd0, flush}, {31'd0, m_flush});
            if (m_flush) check("R6 redirect_pc", redirect_pc, HVEC);
            check("R6 epc", epc, m_epc);
            check("R6 cause", {28'd0, cause}, {28'd0, m_cause});
        end
    end

    task automatic issue(input bit v, input logic [31:0] pc, input bit e, input logic [3:0] c,
                         input bit rfe, input logic [4:0] ra, input logic [31:0] rd,
                         input bit se, input logic [31:0] sa, input logic [31:0] sd);
        @(negedge clk);
        in_valid = v; in_pc = pc; in_exc = e; in_cause = c;
        in_rf_en = rfe; in_rf_addr = ra; in_rf_data = rd;
        in_st_en = se; in_st_addr = sa; in_st_data = sd;
    endtask

    task automatic bubble();
        issue(0, 32'hdead_0000, 1, 4'hf, 1, 5'd31, 32'hffff_ffff, 1, 32'hffff, 32'h1);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 epc", epc, 0);
        check("R1 cause", {28'd0, cause}, 0);
        check("R1 flush", {31'd0, flush}, 0);
        check("R1 writes", {30'd0, rf_we, mem_we}, 0);
        @(negedge clk); rst = 0;
        check("R1 flush after reset", {31'd0, flush}, 0);

        issue(1, 32'h10, 0, 0, 1, 5'd5, 32'h11, 0, 0, 0);
        bubble();
        check("R2 rf_we", {31'd0, rf_we}, 1);
        check("R2 rf_waddr", {27'd0, rf_waddr}, 5);
        check("R2 rf_wdata", rf_wdata, 32'h11);

        issue(1, 32'h14, 0, 0, 0, 0, 0, 1, 32'h40, 32'hab);
        bubble();
        check("R3 mem_we", {31'd0, mem_we}, 1);
        check("R3 mem_addr", mem_addr, 32'h40);
        check("R3 mem_wdata", mem_wdata, 32'hab);

        issue(1, 32'h18, 0, 0, 1, 5'd6, 32'h66, 1, 32'h44, 32'hcd);
        bubble();
        check("R10 both writes", {30'd0, rf_we, mem_we}, 32'd3);

        bubble();
        check("R4 bubble writes", {30'd0, rf_we, mem_we}, 0);
        check("R4 bubble flush", {31'd0, flush}, 0);
        check("R4 epc unchanged", epc, 0);

        issue(1, 32'h100, 0, 0, 1, 5'd7, 32'h77, 1, 32'h50, 32'h55);      // older
        issue(1, 32'h104, 1, 4'd3, 1, 5'd8, 32'h88, 1, 32'h54, 32'h99);   // faulting
        check("R8 older rf_we", {31'd0, rf_we}, 1);
        check("R8 older rf_waddr", {27'd0, rf_waddr}, 7);
        check("R8 older mem_we", {31'd0, mem_we}, 1);
        issue(1, 32'h108, 1, 4'd5, 1, 5'd9, 32'h9, 0, 0, 0);              // younger, flagged
        check("R5 no writes", {30'd0, rf_we, mem_we}, 0);
        check("R5 flush not yet", {31'd0, flush}, 0);
        issue(1, 32'h10c, 0, 0, 1, 5'd11, 32'hb, 1, 32'h60, 32'h6);       // younger
        check("R6 flush", {31'd0, flush}, 1);
        check("R6 redirect", redirect_pc, HVEC);
        check("R6 epc", epc, 32'h104);
        check("R6 cause", {28'd0, cause}, 3);
        issue(1, HVEC, 0, 0, 1, 5'd10, 32'haa, 0, 0, 0);                  // handler
        check("R7 dropped writes", {30'd0, rf_we, mem_we}, 0);
        check("R7 flush one cycle", {31'd0, flush}, 0);
        bubble();
        check("R7 no second trap", {31'd0, flush}, 0);
        check("R7 cause kept", {28'd0, cause}, 3);
        check("R7 resume rf_we", {31'd0, rf_we}, 1);
        check("R7 resume rf_waddr", {27'd0, rf_waddr}, 10);

        issue(1, 32'h300, 1, 4'd2, 0, 0, 0, 0, 0, 0);
        issue(1, 32'h304, 1, 4'd6, 0, 0, 0, 0, 0, 0);
        bubble();
        bubble();
        check("R9 oldest epc", epc, 32'h300);
        check("R9 oldest cause", {28'd0, cause}, 2);
        check("R9 no second flush", {31'd0, flush}, 0);

        for (int k = 0; k < 2000; k++) begin
            logic [31:0] r;
            r = $urandom;
            issue(r[0] | r[1], {$urandom} & 32'hffff_fffc, r[4:2] == 3'd0, r[8:5],
                  r[9], r[14:10], $urandom, r[15], $urandom, $urandom);
        end
        bubble();
        bubble();
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule